// File: doc/BRIEF.md
# Domain Access Guard

This block decides, one cycle after a request, whether a memory access to a page or section may go ahead. Each page belongs to one of sixteen protection domains. A control word holds a 2-bit mode field for every domain. The field selected by the request's domain number chooses how the access is judged:

- A manager domain lets every access through.
- A client domain defers to the page's own 2-bit permission code, the privilege level of the request and whether it reads or writes.
- A domain with no access refuses everything.

The control word is loaded through a simple write port. Rewriting it changes the rights of all sixteen domains in one step. This lets a context switch be done by replacing a single word, with the page tables left untouched. Every response is either a grant or a fault. A fault carries a one-bit type that tells a domain fault apart from a permission fault.

Top module: `dom_access_guard`

## Requirements
- R1: After reset the control word reads zero, no response is valid, and the first access to any domain is refused with a domain fault.
- R2: The mode of domain n is taken from control-word bits [2n+1:2n]. A field set for one domain has no effect on its neighbours, and the written word reads back unchanged on `cfg_rdata`.
- R3: When the mode field is 11 (manager), every access is granted, whatever the permission code, privilege level or direction.
- R4: When the mode field is 00 (no access) or 10 (reserved), every access is refused with `rsp_ftype` = 0 (domain fault).
- R5: When the mode field is 01 (client) and the permission code is 00, every access is refused with `rsp_ftype` = 1 (permission fault).
- R6: In a client domain, permission code 01 grants privileged reads and writes and refuses user accesses with a permission fault.
- R7: In a client domain, permission code 10 grants privileged reads and writes and user reads, and refuses user writes with a permission fault.
- R8: In a client domain, permission code 11 grants every access.
- R9: A control-word write is first used by a request presented in the cycle after the write. A request presented in the same cycle as the write is judged against the old word.
- R10: The response appears in the cycle after the request. `rsp_grant` and `rsp_fault` are never high together, exactly one of them is high while `rsp_valid` is high, and both are low while it is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control-word write strobe |
| cfg_wdata | input | 32 | New control word, 2 bits per domain |
| cfg_rdata | output | 32 | Current control word |
| req_valid | input | 1 | Access request present |
| req_domain | input | 4 | Domain number of the page being accessed |
| req_ap | input | 2 | Page permission code |
| req_priv | input | 1 | 1 = privileged access, 0 = user access |
| req_write | input | 1 | 1 = write, 0 = read |
| rsp_valid | output | 1 | Decision present (one cycle after the request) |
| rsp_grant | output | 1 | Access allowed |
| rsp_fault | output | 1 | Access refused |
| rsp_ftype | output | 1 | Fault type: 0 = domain fault, 1 = permission fault |

## Verification
A vector table sets a control word and then makes one access. It walks every mode encoding against different permission codes, privilege levels and directions:

- Manager accesses with a permission code of 00 separate the bypass from the client path.
- User reads and writes under codes 01 and 10 separate the two restricted permission levels.
- The reserved mode separates "treated as no access" from "treated as client".

Single-field words at domains 0, 1, 4–6 and 15 expose any off-by-one in the field slicing. Directed tests cover the reset state, idle cycles, and a write presented in the same cycle as a request, which shows on which side of the write the decision falls.

// File: rtl/dom_guard_pkg.sv
package dom_guard_pkg;

    localparam int unsigned MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_NONE    = 2'b00,
        MODE_CLIENT  = 2'b01,
        MODE_RSVD    = 2'b10,
        MODE_MANAGER = 2'b11
    } dom_mode_e;

    typedef enum logic [1:0] {
        PERM_DENY  = 2'b00,
        PERM_PRIV  = 2'b01,
        PERM_UREAD = 2'b10,
        PERM_FULL  = 2'b11
    } page_perm_e;

    localparam logic FT_DOMAIN = 1'b0;
    localparam logic FT_PERM   = 1'b1;

    typedef struct packed {
        logic valid;
        logic grant;
        logic fault;
        logic ftype;
    } guard_rsp_t;

endpackage

// File: rtl/dag_ctrl_reg.sv
module dag_ctrl_reg #(
    parameter int unsigned NUM_DOM = 16,
    parameter int unsigned MODE_W  = 2,
    localparam int unsigned REG_W  = NUM_DOM * MODE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] word
);

    typedef struct packed {
        logic [REG_W-1:0] word;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.word = wdata;
        end
    end

    // All-zero reset leaves every domain without access.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word = st_q.word;

endmodule

// File: rtl/dag_field_sel.sv
module dag_field_sel #(
    parameter int unsigned NUM_DOM = 16,
    parameter int unsigned MODE_W  = 2,
    localparam int unsigned REG_W  = NUM_DOM * MODE_W,
    localparam int unsigned DOM_W  = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1
) (
    input  logic [REG_W-1:0]  word,
    input  logic [DOM_W-1:0]  domain,
    output logic [MODE_W-1:0] mode
);

    logic [MODE_W-1:0] field [NUM_DOM];

    for (genvar g = 0; g < NUM_DOM; g++) begin : g_field
        assign field[g] = word[g*MODE_W +: MODE_W];
    end

    assign mode = field[domain];

endmodule

// File: rtl/dag_perm_eval.sv
module dag_perm_eval
    import dom_guard_pkg::*;
(
    input  logic [1:0] mode,
    input  logic [1:0] ap,
    input  logic       priv,
    input  logic       write,
    output logic       allow,
    output logic       perm_fault
);

    logic client_ok;

    always_comb begin
        unique case (page_perm_e'(ap))
            PERM_DENY:  client_ok = 1'b0;
            PERM_PRIV:  client_ok = priv;
            PERM_UREAD: client_ok = priv | ~write;
            PERM_FULL:  client_ok = 1'b1;
            default:    client_ok = 1'b0;
        endcase
    end

    always_comb begin
        allow      = 1'b0;
        perm_fault = 1'b0;
        unique case (dom_mode_e'(mode))
            MODE_MANAGER: allow = 1'b1;
            MODE_CLIENT: begin
                allow      = client_ok;
                perm_fault = ~client_ok;
            end
            default: begin
                allow      = 1'b0;
                perm_fault = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/dom_access_guard.sv
module dom_access_guard
    import dom_guard_pkg::*;
#(
    parameter int unsigned NUM_DOM = 16,
    localparam int unsigned REG_W  = NUM_DOM * MODE_W,
    localparam int unsigned DOM_W  = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    input  logic             req_valid,
    input  logic [DOM_W-1:0] req_domain,
    input  logic [1:0]       req_ap,
    input  logic             req_priv,
    input  logic             req_write,
    output logic             rsp_valid,
    output logic             rsp_grant,
    output logic             rsp_fault,
    output logic             rsp_ftype
);

    logic [REG_W-1:0]  ctrl_word;
    logic [MODE_W-1:0] dom_mode;
    logic              allow;
    logic              perm_fault;

    dag_ctrl_reg #(.NUM_DOM(NUM_DOM), .MODE_W(MODE_W)) ctrl_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .word  (ctrl_word)
    );

    dag_field_sel #(.NUM_DOM(NUM_DOM), .MODE_W(MODE_W)) sel_i (
        .word   (ctrl_word),
        .domain (req_domain),
        .mode   (dom_mode)
    );

    dag_perm_eval eval_i (
        .mode       (dom_mode),
        .ap         (req_ap),
        .priv       (req_priv),
        .write      (req_write),
        .allow      (allow),
        .perm_fault (perm_fault)
    );

    guard_rsp_t rsp_d, rsp_q;

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = req_valid;
        rsp_d.grant = req_valid & allow;
        rsp_d.fault = req_valid & ~allow;
        rsp_d.ftype = (req_valid & ~allow & perm_fault) ? FT_PERM : FT_DOMAIN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign cfg_rdata = ctrl_word;
    assign rsp_valid = rsp_q.valid;
    assign rsp_grant = rsp_q.grant;
    assign rsp_fault = rsp_q.fault;
    assign rsp_ftype = rsp_q.ftype;

endmodule

// File: rtl/dag_checker.sv
module dag_checker #(
    parameter int unsigned NUM_DOM = 16,
    localparam int unsigned REG_W  = NUM_DOM * 2,
    localparam int unsigned DOM_W  = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [REG_W-1:0] cfg_wdata,
    input logic [REG_W-1:0] cfg_rdata,
    input logic             req_valid,
    input logic [DOM_W-1:0] req_domain,
    input logic [1:0]       req_ap,
    input logic             req_priv,
    input logic             req_write,
    input logic             rsp_valid,
    input logic             rsp_grant,
    input logic             rsp_fault,
    input logic             rsp_ftype
);

    logic [1:0] cur_field;
    assign cur_field = cfg_rdata[{req_domain, 1'b0} +: 2];

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cfg_rdata == '0 && !rsp_valid));

    assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_rdata == $past(cfg_wdata)));

    assert_manager_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cur_field == 2'b11) |=> (rsp_grant && !rsp_fault));

    assert_domain_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cur_field[0] == 1'b0) |=> (rsp_fault && !rsp_ftype));

    assert_perm_deny_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cur_field == 2'b01 && req_ap == 2'b00) |=> (rsp_fault && rsp_ftype));

    assert_user_priv_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cur_field == 2'b01 && req_ap == 2'b01 && !req_priv) |=> (rsp_fault && rsp_ftype));

    assert_user_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cur_field == 2'b01 && req_ap == 2'b10 && !req_priv && req_write)
        |=> (rsp_fault && rsp_ftype));

    assert_full_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cur_field == 2'b01 && req_ap == 2'b11) |=> rsp_grant);

    assert_resp_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(rst_n) |-> (rsp_valid == $past(req_valid)));

    assert_one_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_grant ^ rsp_fault));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_grant && !rsp_fault));

endmodule

bind dom_access_guard dag_checker #(.NUM_DOM(NUM_DOM)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .req_valid  (req_valid),
    .req_domain (req_domain),
    .req_ap     (req_ap),
    .req_priv   (req_priv),
    .req_write  (req_write),
    .rsp_valid  (rsp_valid),
    .rsp_grant  (rsp_grant),
    .rsp_fault  (rsp_fault),
    .rsp_ftype  (rsp_ftype)
);

// File: tb/dom_access_guard_tb.sv
module dom_access_guard_tb_top;

    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC       = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic [3:0]  req_domain = '0;
    logic [1:0]  req_ap = '0;
    logic        req_priv = 1'b0;
    logic        req_write = 1'b0;
    logic        rsp_valid, rsp_grant, rsp_fault, rsp_ftype;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dom_access_guard dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_domain(req_domain),
        .req_ap(req_ap), .req_priv(req_priv), .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_fault(rsp_fault),
        .rsp_ftype(rsp_ftype)
    );

    // {word[41:10], domain[9:6], ap[5:4], priv[3], write[2], exp_grant[1], exp_ftype[0]}
    localparam logic [41:0] VEC [NVEC] = '{
        {32'h0000_0003, 4'd0,  2'b00, 1'b0, 1'b1, 1'b1, 1'b0}, // R3 manager, user write, ap 00
        {32'h0000_0003, 4'd0,  2'b00, 1'b1, 1'b0, 1'b1, 1'b0}, // R3
        {32'h0000_0001, 4'd0,  2'b00, 1'b1, 1'b0, 1'b0, 1'b1}, // R5
        {32'h0000_0001, 4'd0,  2'b01, 1'b1, 1'b1, 1'b1, 1'b0}, // R6 priv write
        {32'h0000_0001, 4'd0,  2'b01, 1'b0, 1'b0, 1'b0, 1'b1}, // R6 user read
        {32'h0000_0004, 4'd1,  2'b10, 1'b0, 1'b0, 1'b1, 1'b0}, // R7 user read
        {32'h0000_0004, 4'd1,  2'b10, 1'b0, 1'b1, 1'b0, 1'b1}, // R7 user write
        {32'h0000_0004, 4'd1,  2'b10, 1'b1, 1'b1, 1'b1, 1'b0}, // R7 priv write
        {32'h0000_0004, 4'd1,  2'b11, 1'b0, 1'b1, 1'b1, 1'b0}, // R8
        {32'h0000_0004, 4'd0,  2'b11, 1'b1, 1'b0, 1'b0, 1'b0}, // R4 no access
        {32'h8000_0000, 4'd15, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0}, // R4 reserved
        {32'hC000_0000, 4'd15, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0}, // R3 top domain
        {32'h4000_0000, 4'd15, 2'b11, 1'b0, 1'b0, 1'b1, 1'b0}, // R8 top domain
        {32'h0000_0C00, 4'd5,  2'b00, 1'b0, 1'b0, 1'b1, 1'b0}, // R2 domain 5
        {32'h0000_0C00, 4'd4,  2'b00, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 neighbour below
        {32'h0000_0C00, 4'd6,  2'b00, 1'b0, 1'b0, 1'b0, 1'b0}  // R2 neighbour above
    };

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic write_word(input logic [31:0] w);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic access(input logic [3:0] d, input logic [1:0] ap,
                          input logic pv, input logic wr);
        @(negedge clk);
        req_valid = 1'b1;
        req_domain = d;
        req_ap = ap;
        req_priv = pv;
        req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_rsp(input string tag, input bit g, input bit ft);
        check(rsp_valid == 1'b1, tag, "valid", 32'(rsp_valid), 32'h1);
        check({rsp_grant, rsp_fault} == {g, ~g}, tag, "grant/fault",
              32'({rsp_grant, rsp_fault}), 32'({g, ~g}));
        if (!g) check(rsp_ftype == ft, tag, "ftype", 32'(rsp_ftype), 32'(ft));
    endtask

    function automatic string tag_of(input int i);
        case (i)
            0, 1, 11:    return "R3";
            2:           return "R5";
            3, 4:        return "R6";
            5, 6, 7:     return "R7";
            8, 12:       return "R8";
            9, 10:       return "R4";
            default:     return "R2";
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(cfg_rdata == 32'h0, "R1", "word at reset", cfg_rdata, 32'h0);
        check(!rsp_valid && !rsp_grant && !rsp_fault, "R1", "rsp at reset",
              32'({rsp_valid, rsp_grant, rsp_fault}), 32'h0);
        rst_n = 1'b1;
        // R1: first access after reset refused with a domain fault
        access(4'd7, 2'b11, 1'b1, 1'b0);
        expect_rsp("R1", 1'b0, 1'b0);
        // R10: idle cycle keeps every response output low
        @(negedge clk);
        check(!rsp_valid && !rsp_grant && !rsp_fault, "R10", "idle rsp",
              32'({rsp_valid, rsp_grant, rsp_fault}), 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            write_word(VEC[i][41:10]);
            check(cfg_rdata == VEC[i][41:10], "R2", "readback", cfg_rdata, VEC[i][41:10]);
            access(VEC[i][9:6], VEC[i][5:4], VEC[i][3], VEC[i][2]);
            expect_rsp(tag_of(i), VEC[i][1], VEC[i][0]);
        end

        // R9: write and request in the same cycle use the old word
        write_word(32'h0);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = 32'hFFFF_FFFF;
        req_valid = 1'b1;
        req_domain = 4'd9;
        req_ap = 2'b00;
        req_priv = 1'b0;
        req_write = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        req_valid = 1'b0;
        expect_rsp("R9", 1'b0, 1'b0);
        // R9: the next request sees the new word
        access(4'd9, 2'b00, 1'b0, 1'b1);
        expect_rsp("R9", 1'b1, 1'b0);
        // R9: switching the word back removes access at once
        write_word(32'h0000_0000);
        access(4'd9, 2'b00, 1'b0, 1'b1);
        expect_rsp("R9", 1'b0, 1'b0);

        // R10: back-to-back requests each answered one cycle later
        write_word(32'h0000_0010); // domain 2 client
        @(negedge clk);
        req_valid = 1'b1; req_domain = 4'd2; req_ap = 2'b11; req_priv = 1'b0; req_write = 1'b1;
        @(negedge clk);
        expect_rsp("R10", 1'b1, 1'b0);
        req_ap = 2'b00;
        @(negedge clk);
        req_valid = 1'b0;
        expect_rsp("R10", 1'b0, 1'b1);
        @(negedge clk);
        check(!rsp_valid, "R10", "valid drops", 32'(rsp_valid), 32'h0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule